// File: doc/BRIEF.md
# Speculative Load/Store Ordering Checker

This block keeps two small program-ordered queues, one for in-flight stores and one for in-flight loads. Each entry is tagged with a sequence number that gives its age. A load looks up its address among the stores that are older than it and whose addresses are already known. If one or more of them match, the load takes the data of the youngest matching store. If none match, the load is sent to memory. A load never waits for an older store whose address is still unknown.

Because loads may run ahead of unresolved stores, ordering errors are caught afterwards. Stores leave the store queue in order. As each one leaves, its address is compared with every younger load that has already executed. A load that read a stale value is flagged. Write and upgrade addresses observed on the coherent bus are compared with executed loads in the same way. The block reports the oldest flagged load so that the pipeline can replay from it. That pipeline then clears the younger work through the flush input.

Top module: `lsq_disambig`

## Requirements
- R1: After reset both queues are empty, `st_full` and `ld_full` are 0, and `replay_valid` is 0.
- R2: While `ld_exec_valid` is 1, `ld_fwd_hit` is 1 in the same cycle when a store older than `ld_exec_seq` holds a known address equal to `ld_exec_addr`. In that case `ld_fwd_data` carries the data of the youngest such store. Stores younger than the load are ignored.
- R3: A load with no older matching store whose address is known gets `ld_fwd_hit` = 0. This holds even when some older stores still have no address.
- R4: Address matches compare all 32 bits. Two addresses that differ only in bit 31, or only in bit 0, do not match.
- R5: `st_commit_valid` retires the oldest store. In the next cycle, every younger executed load at the same address is flagged for replay, except a load that took its data from that store or from a younger store. Older loads and loads not yet executed are not flagged.
- R6: A `snoop_valid` pulse flags every executed load whose address equals `snoop_addr`, whatever its age. Loads that have not executed are not flagged.
- R7: From the cycle after a flag is set, `replay_valid` is 1 and `replay_seq` gives the sequence number of the oldest flagged load.
- R8: `flush_valid` removes, in the next cycle, every entry in both queues whose sequence number is strictly younger than `flush_seq`. Older entries and the entry equal to `flush_seq` are kept.
- R9: `st_full` and `ld_full` are 1 when their queue holds 8 entries. `ld_retire_valid` frees the oldest load, and a store commit frees the oldest store.
- R10: Age is compared modulo 2^6 on the sequence numbers. Ordering stays correct when the numbers wrap past 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_alloc_valid | input | 1 | Allocate a store entry at the tail |
| st_alloc_seq | input | 6 | Sequence number of the new store |
| st_full | output | 1 | Store queue holds 8 entries |
| st_exec_valid | input | 1 | Store address and data resolved |
| st_exec_seq | input | 6 | Sequence number of the resolving store |
| st_exec_addr | input | 32 | Store word address |
| st_exec_data | input | 32 | Store data |
| st_commit_valid | input | 1 | Retire the oldest store and check loads against it |
| ld_alloc_valid | input | 1 | Allocate a load entry at the tail |
| ld_alloc_seq | input | 6 | Sequence number of the new load |
| ld_full | output | 1 | Load queue holds 8 entries |
| ld_exec_valid | input | 1 | Load executes this cycle |
| ld_exec_seq | input | 6 | Sequence number of the executing load |
| ld_exec_addr | input | 32 | Load word address |
| ld_fwd_hit | output | 1 | Load data comes from a store entry |
| ld_fwd_data | output | 32 | Forwarded store data |
| ld_retire_valid | input | 1 | Free the oldest load |
| snoop_valid | input | 1 | Remote write or upgrade observed |
| snoop_addr | input | 32 | Address of the remote write or upgrade |
| flush_valid | input | 1 | Remove entries younger than `flush_seq` |
| flush_seq | input | 6 | Flush boundary sequence number |
| replay_valid | output | 1 | At least one load is flagged |
| replay_seq | output | 6 | Sequence number of the oldest flagged load |

## Verification
The hardest situation to reach from the ports is a load that issued while some older stores still had no address, followed later by one of those stores resolving to the load's address. The bench sweeps every combination of four older stores. For each store it chooses whether the address is known before the load executes, and whether the address matches. It then resolves the remaining stores and commits all four. The replay result must depend only on whether a matching store younger than the forwarding source was hidden at execute time. Sequence numbers keep rising across the sweep, so the age comparisons also cross the wrap point.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

   // True when sequence number a is older than b, modulo 2^w.
   function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b, input int w);
      logic [31:0] d;
      d = (a - b) << (32 - w);
      return d[31];
   endfunction

endpackage

// File: rtl/lsq_store_queue.sv
module lsq_store_queue
   import lsq_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int SEQ_W  = 6,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [SEQ_W-1:0]  alloc_seq,
   input  logic              exec_valid,
   input  logic [SEQ_W-1:0]  exec_seq,
   input  logic [ADDR_W-1:0] exec_addr,
   input  logic [DATA_W-1:0] exec_data,
   input  logic              commit_valid,
   input  logic              flush_valid,
   input  logic [SEQ_W-1:0]  flush_seq,
   output logic              full,
   output logic [PTR_W-1:0]  head,
   output logic              ent_valid [DEPTH],
   output logic              ent_known [DEPTH],
   output logic [ADDR_W-1:0] ent_addr  [DEPTH],
   output logic [DATA_W-1:0] ent_data  [DEPTH],
   output logic [SEQ_W-1:0]  ent_seq   [DEPTH],
   output logic              commit_ok,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [SEQ_W-1:0]  commit_seq
);

   logic [PTR_W-1:0] tail;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] keep_cnt;
   logic             drop [DEPTH];
   logic             alloc_ok;

   assign full        = (count == CNT_W'(DEPTH));
   assign alloc_ok    = alloc_valid && !full;
   assign commit_ok   = commit_valid && (count != '0);
   assign commit_addr = ent_addr[head];
   assign commit_seq  = ent_seq[head];

   always_comb begin
      keep_cnt = '0;
      for (int i = 0; i < DEPTH; i++) begin
         drop[i] = ent_valid[i] && seq_older(32'(flush_seq), 32'(ent_seq[i]), SEQ_W);
         if (ent_valid[i] && !drop[i]) keep_cnt = keep_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            ent_valid[i] <= 1'b0;
            ent_known[i] <= 1'b0;
         end
      end else if (flush_valid) begin
         for (int i = 0; i < DEPTH; i++)
            if (drop[i]) ent_valid[i] <= 1'b0;
         count <= keep_cnt;
         tail  <= head + keep_cnt[PTR_W-1:0];
      end else begin
         if (exec_valid) begin
            for (int i = 0; i < DEPTH; i++) begin
               if (ent_valid[i] && ent_seq[i] == exec_seq) begin
                  ent_known[i] <= 1'b1;
                  ent_addr[i]  <= exec_addr;
                  ent_data[i]  <= exec_data;
               end
            end
         end
         if (commit_ok) begin
            ent_valid[head] <= 1'b0;
            head            <= head + 1'b1;
         end
         if (alloc_ok) begin
            ent_valid[tail] <= 1'b1;
            ent_known[tail] <= 1'b0;
            ent_seq[tail]   <= alloc_seq;
            tail            <= tail + 1'b1;
         end
         count <= count + CNT_W'(alloc_ok) - CNT_W'(commit_ok);
      end
   end

   // R5
   commit_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |-> (count != '0));

   // R9
   st_alloc_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_valid |-> !full);

endmodule

// File: rtl/lsq_fwd_select.sv
module lsq_fwd_select
   import lsq_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int SEQ_W  = 6,
   localparam int PTR_W = $clog2(DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [SEQ_W-1:0]  ld_seq,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [PTR_W-1:0]  head,
   input  logic              ent_valid [DEPTH],
   input  logic              ent_known [DEPTH],
   input  logic [ADDR_W-1:0] ent_addr  [DEPTH],
   input  logic [DATA_W-1:0] ent_data  [DEPTH],
   input  logic [SEQ_W-1:0]  ent_seq   [DEPTH],
   output logic              hit,
   output logic [DATA_W-1:0] data,
   output logic [SEQ_W-1:0]  src_seq
);

   logic [DEPTH-1:0] cand;

   // One comparator per store entry: full-width address, age relative to the load.
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign cand[g] = ent_valid[g] && ent_known[g] && (ent_addr[g] == ld_addr)
                       && seq_older(32'(ent_seq[g]), 32'(ld_seq), SEQ_W);
   end

   // Walk from the oldest store; the last candidate seen is the youngest.
   always_comb begin
      logic [PTR_W-1:0] idx;
      hit     = 1'b0;
      data    = '0;
      src_seq = '0;
      for (int k = 0; k < DEPTH; k++) begin
         idx = head + PTR_W'(k);
         if (cand[idx]) begin
            hit     = ld_valid;
            data    = ent_data[idx];
            src_seq = ent_seq[idx];
         end
      end
   end

   // R2
   fwd_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> seq_older(32'(src_seq), 32'(ld_seq), SEQ_W));

endmodule

// File: rtl/lsq_load_queue.sv
module lsq_load_queue
   import lsq_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int SEQ_W  = 6,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [SEQ_W-1:0]  alloc_seq,
   output logic              full,
   input  logic              exec_valid,
   input  logic [SEQ_W-1:0]  exec_seq,
   input  logic [ADDR_W-1:0] exec_addr,
   input  logic              exec_fwd,
   input  logic [SEQ_W-1:0]  exec_fwd_seq,
   input  logic              retire_valid,
   input  logic              commit_valid,
   input  logic [SEQ_W-1:0]  commit_seq,
   input  logic [ADDR_W-1:0] commit_addr,
   input  logic              snoop_valid,
   input  logic [ADDR_W-1:0] snoop_addr,
   input  logic              flush_valid,
   input  logic [SEQ_W-1:0]  flush_seq,
   output logic              replay_valid,
   output logic [SEQ_W-1:0]  replay_seq
);

   logic              valid [DEPTH];
   logic              done  [DEPTH];
   logic              fwd   [DEPTH];
   logic [SEQ_W-1:0]  fseq  [DEPTH];
   logic [ADDR_W-1:0] addr  [DEPTH];
   logic [SEQ_W-1:0]  seq   [DEPTH];
   logic              flag  [DEPTH];
   logic [PTR_W-1:0]  head, tail;
   logic [CNT_W-1:0]  count, keep_cnt;
   logic [DEPTH-1:0]  drop, hit_commit, hit_snoop, bad_flag;
   logic              alloc_ok, retire_ok;

   assign full      = (count == CNT_W'(DEPTH));
   assign alloc_ok  = alloc_valid && !full;
   assign retire_ok = retire_valid && (count != '0);

   always_comb begin
      keep_cnt = '0;
      for (int i = 0; i < DEPTH; i++) begin
         drop[i] = valid[i] && seq_older(32'(flush_seq), 32'(seq[i]), SEQ_W);
         if (valid[i] && !drop[i]) keep_cnt = keep_cnt + 1'b1;
         // A load is stale if it executed after the committing store in age,
         // at the same address, without data from that store or a younger one.
         hit_commit[i] = commit_valid && valid[i] && done[i]
                         && seq_older(32'(commit_seq), 32'(seq[i]), SEQ_W)
                         && (addr[i] == commit_addr)
                         && !(fwd[i] && !seq_older(32'(fseq[i]), 32'(commit_seq), SEQ_W));
         hit_snoop[i]  = snoop_valid && valid[i] && done[i] && (addr[i] == snoop_addr);
         bad_flag[i]   = valid[i] && flag[i] && !done[i];
      end
   end

   // Oldest flagged load, walking from the head.
   always_comb begin
      logic [PTR_W-1:0] idx;
      replay_valid = 1'b0;
      replay_seq   = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         idx = head + PTR_W'(k);
         if (valid[idx] && flag[idx]) begin
            replay_valid = 1'b1;
            replay_seq   = seq[idx];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            valid[i] <= 1'b0;
            done[i]  <= 1'b0;
            flag[i]  <= 1'b0;
            fwd[i]   <= 1'b0;
         end
      end else if (flush_valid) begin
         for (int i = 0; i < DEPTH; i++)
            if (drop[i]) valid[i] <= 1'b0;
         count <= keep_cnt;
         tail  <= head + keep_cnt[PTR_W-1:0];
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (hit_commit[i] || hit_snoop[i]) flag[i] <= 1'b1;
            if (exec_valid && valid[i] && seq[i] == exec_seq) begin
               done[i] <= 1'b1;
               addr[i] <= exec_addr;
               fwd[i]  <= exec_fwd;
               fseq[i] <= exec_fwd_seq;
            end
         end
         if (retire_ok) begin
            valid[head] <= 1'b0;
            head        <= head + 1'b1;
         end
         if (alloc_ok) begin
            valid[tail] <= 1'b1;
            done[tail]  <= 1'b0;
            flag[tail]  <= 1'b0;
            fwd[tail]   <= 1'b0;
            seq[tail]   <= alloc_seq;
            tail        <= tail + 1'b1;
         end
         count <= count + CNT_W'(alloc_ok) - CNT_W'(retire_ok);
      end
   end

   // R6
   snoop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_valid && !retire_valid && (|hit_snoop)) |=> replay_valid);

   // R7
   flag_needs_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_flag == '0);

   // R9
   ld_alloc_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_valid |-> !full);

endmodule

// File: rtl/lsq_disambig.sv
module lsq_disambig
   import lsq_pkg::*;
#(
   parameter int SQ_DEPTH = 8,
   parameter int LQ_DEPTH = 8,
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int SEQ_W    = 6,
   localparam int SQ_PTR_W = $clog2(SQ_DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_alloc_valid,
   input  logic [SEQ_W-1:0]  st_alloc_seq,
   output logic              st_full,
   input  logic              st_exec_valid,
   input  logic [SEQ_W-1:0]  st_exec_seq,
   input  logic [ADDR_W-1:0] st_exec_addr,
   input  logic [DATA_W-1:0] st_exec_data,
   input  logic              st_commit_valid,
   input  logic              ld_alloc_valid,
   input  logic [SEQ_W-1:0]  ld_alloc_seq,
   output logic              ld_full,
   input  logic              ld_exec_valid,
   input  logic [SEQ_W-1:0]  ld_exec_seq,
   input  logic [ADDR_W-1:0] ld_exec_addr,
   output logic              ld_fwd_hit,
   output logic [DATA_W-1:0] ld_fwd_data,
   input  logic              ld_retire_valid,
   input  logic              snoop_valid,
   input  logic [ADDR_W-1:0] snoop_addr,
   input  logic              flush_valid,
   input  logic [SEQ_W-1:0]  flush_seq,
   output logic              replay_valid,
   output logic [SEQ_W-1:0]  replay_seq
);

   // Elaboration-time parameter checks.
   if ((SQ_DEPTH & (SQ_DEPTH - 1)) != 0 || SQ_DEPTH < 2) begin : g_bad_sq
      $error("SQ_DEPTH must be a power of two of at least 2");
   end
   if ((LQ_DEPTH & (LQ_DEPTH - 1)) != 0 || LQ_DEPTH < 2) begin : g_bad_lq
      $error("LQ_DEPTH must be a power of two of at least 2");
   end
   if (SEQ_W > 32 || (1 << (SEQ_W - 1)) < (SQ_DEPTH + LQ_DEPTH)) begin : g_bad_seq
      $error("SEQ_W too narrow for the in-flight window");
   end

   logic [SQ_PTR_W-1:0] sq_head;
   logic                sq_valid [SQ_DEPTH];
   logic                sq_known [SQ_DEPTH];
   logic [ADDR_W-1:0]   sq_addr  [SQ_DEPTH];
   logic [DATA_W-1:0]   sq_data  [SQ_DEPTH];
   logic [SEQ_W-1:0]    sq_seq   [SQ_DEPTH];
   logic                sq_commit_ok;
   logic [ADDR_W-1:0]   sq_commit_addr;
   logic [SEQ_W-1:0]    sq_commit_seq;
   logic [SEQ_W-1:0]    fwd_src_seq;

   lsq_store_queue #(
      .DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)
   ) u_sq (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_valid (st_alloc_valid),
      .alloc_seq   (st_alloc_seq),
      .exec_valid  (st_exec_valid),
      .exec_seq    (st_exec_seq),
      .exec_addr   (st_exec_addr),
      .exec_data   (st_exec_data),
      .commit_valid(st_commit_valid),
      .flush_valid (flush_valid),
      .flush_seq   (flush_seq),
      .full        (st_full),
      .head        (sq_head),
      .ent_valid   (sq_valid),
      .ent_known   (sq_known),
      .ent_addr    (sq_addr),
      .ent_data    (sq_data),
      .ent_seq     (sq_seq),
      .commit_ok   (sq_commit_ok),
      .commit_addr (sq_commit_addr),
      .commit_seq  (sq_commit_seq)
   );

   lsq_fwd_select #(
      .DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)
   ) u_fwd (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_valid (ld_exec_valid),
      .ld_seq   (ld_exec_seq),
      .ld_addr  (ld_exec_addr),
      .head     (sq_head),
      .ent_valid(sq_valid),
      .ent_known(sq_known),
      .ent_addr (sq_addr),
      .ent_data (sq_data),
      .ent_seq  (sq_seq),
      .hit      (ld_fwd_hit),
      .data     (ld_fwd_data),
      .src_seq  (fwd_src_seq)
   );

   lsq_load_queue #(
      .DEPTH(LQ_DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)
   ) u_lq (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_valid (ld_alloc_valid),
      .alloc_seq   (ld_alloc_seq),
      .full        (ld_full),
      .exec_valid  (ld_exec_valid),
      .exec_seq    (ld_exec_seq),
      .exec_addr   (ld_exec_addr),
      .exec_fwd    (ld_fwd_hit),
      .exec_fwd_seq(fwd_src_seq),
      .retire_valid(ld_retire_valid),
      .commit_valid(sq_commit_ok),
      .commit_seq  (sq_commit_seq),
      .commit_addr (sq_commit_addr),
      .snoop_valid (snoop_valid),
      .snoop_addr  (snoop_addr),
      .flush_valid (flush_valid),
      .flush_seq   (flush_seq),
      .replay_valid(replay_valid),
      .replay_seq  (replay_seq)
   );

endmodule

// File: tb/lsq_disambig_tb.sv
module lsq_disambig_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_alloc_valid = 0;  logic [5:0]  st_alloc_seq = 0;
   logic        st_full;
   logic        st_exec_valid = 0;   logic [5:0]  st_exec_seq = 0;
   logic [31:0] st_exec_addr = 0;    logic [31:0] st_exec_data = 0;
   logic        st_commit_valid = 0;
   logic        ld_alloc_valid = 0;  logic [5:0]  ld_alloc_seq = 0;
   logic        ld_full;
   logic        ld_exec_valid = 0;   logic [5:0]  ld_exec_seq = 0;
   logic [31:0] ld_exec_addr = 0;
   logic        ld_fwd_hit;          logic [31:0] ld_fwd_data;
   logic        ld_retire_valid = 0;
   logic        snoop_valid = 0;     logic [31:0] snoop_addr = 0;
   logic        flush_valid = 0;     logic [5:0]  flush_seq = 0;
   logic        replay_valid;        logic [5:0]  replay_seq;

   int n_chk = 0, n_bad = 0;
   logic [5:0] nseq = 6'd0;

   always #5 clk = ~clk;

   lsq_disambig u_dut (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic st_alloc(input logic [5:0] s);
      st_alloc_valid = 1; st_alloc_seq = s; @(negedge clk); st_alloc_valid = 0;
   endtask
   task automatic ld_alloc(input logic [5:0] s);
      ld_alloc_valid = 1; ld_alloc_seq = s; @(negedge clk); ld_alloc_valid = 0;
   endtask
   task automatic st_exec(input logic [5:0] s, input logic [31:0] a, input logic [31:0] d);
      st_exec_valid = 1; st_exec_seq = s; st_exec_addr = a; st_exec_data = d;
      @(negedge clk); st_exec_valid = 0;
   endtask
   task automatic ld_exec(input logic [5:0] s, input logic [31:0] a);
      ld_exec_valid = 1; ld_exec_seq = s; ld_exec_addr = a; #1;
   endtask
   task automatic ld_exec_end();
      @(negedge clk); ld_exec_valid = 0;
   endtask
   task automatic commit();
      st_commit_valid = 1; @(negedge clk); st_commit_valid = 0;
   endtask
   task automatic retire();
      ld_retire_valid = 1; @(negedge clk); ld_retire_valid = 0;
   endtask
   task automatic snoop(input logic [31:0] a);
      snoop_valid = 1; snoop_addr = a; @(negedge clk); snoop_valid = 0;
   endtask
   task automatic flush(input logic [5:0] s);
      flush_valid = 1; flush_seq = s; @(negedge clk); flush_valid = 0;
   endtask

   function automatic logic [31:0] other_addr(input logic [31:0] a, input int j);
      case (j)
         0: return a ^ 32'h8000_0000;
         1: return a ^ 32'h0000_0001;
         2: return a ^ 32'h0001_0000;
         default: return a ^ 32'h0000_0100;
      endcase
   endfunction

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk(st_full == 0, "R1 st_full", 32'(st_full), 0);
      chk(ld_full == 0, "R1 ld_full", 32'(ld_full), 0);
      chk(replay_valid == 0, "R1 replay_valid", 32'(replay_valid), 0);

      // Sweep: four older stores, each known/unknown at load time and matching/not.
      for (int km = 0; km < 16; km++) begin
         for (int mm = 0; mm < 16; mm++) begin
            logic [5:0]  base;
            logic [31:0] a;
            int f;
            bit exp_flag;
            base = nseq;
            nseq = nseq + 6'd6;
            a = {km[3:0], mm[3:0], 24'hA5_0C3C};
            for (int j = 0; j < 4; j++) st_alloc(base + 6'(j));
            ld_alloc(base + 6'd4);
            st_alloc(base + 6'd5);
            for (int j = 0; j < 4; j++)
               if (km[j]) st_exec(base + 6'(j), mm[j] ? a : other_addr(a, j), 32'h100 + 32'(j));
            st_exec(base + 6'd5, a, 32'h999);
            f = -1;
            for (int j = 0; j < 4; j++) if (km[j] && mm[j]) f = j;
            ld_exec(base + 6'd4, a);
            // R2 R3 R4 R10 forwarding from youngest older known match
            chk(ld_fwd_hit == (f >= 0), "R2/R3 fwd hit", 32'(ld_fwd_hit), 32'(f >= 0));
            if (f >= 0)
               chk(ld_fwd_data == 32'h100 + 32'(f), "R2 fwd data R10", ld_fwd_data, 32'h100 + 32'(f));
            ld_exec_end();
            for (int j = 0; j < 4; j++)
               if (!km[j]) st_exec(base + 6'(j), mm[j] ? a : other_addr(a, j), 32'h100 + 32'(j));
            exp_flag = 0;
            for (int j = 0; j < 4; j++) if (mm[j] && j > f) exp_flag = 1;
            for (int j = 0; j < 4; j++) commit();
            // R5 R7 replay after commit of a hidden matching store
            chk(replay_valid == exp_flag, "R5 replay_valid", 32'(replay_valid), 32'(exp_flag));
            if (exp_flag)
               chk(replay_seq == base + 6'd4, "R7 replay_seq", 32'(replay_seq), 32'(base + 6'd4));
            flush(base - 6'd1);
            chk(replay_valid == 0, "R8 flush clears", 32'(replay_valid), 0);
         end
      end

      // R5: a committing store never flags an older load.
      begin
         logic [5:0] b;
         b = nseq; nseq = nseq + 6'd2;
         ld_alloc(b); st_alloc(b + 6'd1);
         ld_exec(b, 32'h4000_0010); ld_exec_end();
         st_exec(b + 6'd1, 32'h4000_0010, 32'h77);
         commit();
         chk(replay_valid == 0, "R5 older load untouched", 32'(replay_valid), 0);
         flush(b - 6'd1);
      end

      // R6 R7 R8 R9 snoop checks
      begin
         logic [5:0] b;
         b = nseq; nseq = nseq + 6'd4;
         for (int j = 0; j < 4; j++) ld_alloc(b + 6'(j));
         ld_exec(b + 6'd1, 32'h0000_1000); ld_exec_end();
         ld_exec(b + 6'd2, 32'h0000_1000); ld_exec_end();
         ld_exec(b + 6'd3, 32'h0000_2000); ld_exec_end();
         snoop(32'h8000_1000);
         chk(replay_valid == 0, "R6 snoop no match", 32'(replay_valid), 0);
         snoop(32'h0000_2000);
         chk(replay_valid == 1, "R6 snoop flags", 32'(replay_valid), 1);
         chk(replay_seq == b + 6'd3, "R7 replay_seq single", 32'(replay_seq), 32'(b + 6'd3));
         snoop(32'h0000_1000);
         chk(replay_seq == b + 6'd1, "R7 oldest flagged, R6 unexecuted skipped", 32'(replay_seq), 32'(b + 6'd1));
         flush(b);
         chk(replay_valid == 0, "R8 younger removed", 32'(replay_valid), 0);
         ld_exec(b, 32'h0000_1000); ld_exec_end();
         snoop(32'h0000_1000);
         chk(replay_seq == b && replay_valid, "R8 boundary entry kept", 32'(replay_seq), 32'(b));
         retire();
         chk(replay_valid == 0, "R9 retire frees", 32'(replay_valid), 0);
      end

      // R9 full flags, R8 partial flush through occupancy
      begin
         logic [5:0] b;
         b = nseq; nseq = nseq + 6'd8;
         for (int j = 0; j < 7; j++) begin st_alloc(b + 6'(j)); ld_alloc(b + 6'(j)); end
         chk(st_full == 0, "R9 st_full at 7", 32'(st_full), 0);
         chk(ld_full == 0, "R9 ld_full at 7", 32'(ld_full), 0);
         st_alloc(b + 6'd7); ld_alloc(b + 6'd7);
         chk(st_full == 1, "R9 st_full at 8", 32'(st_full), 1);
         chk(ld_full == 1, "R9 ld_full at 8", 32'(ld_full), 1);
         st_exec(b, 32'h10, 32'h1);
         commit();
         chk(st_full == 0, "R9 commit frees", 32'(st_full), 0);
         retire();
         chk(ld_full == 0, "R9 retire frees", 32'(ld_full), 0);
         flush(b + 6'd3);
         for (int j = 0; j < 4; j++) ld_alloc(nseq + 6'(j));
         chk(ld_full == 0, "R8 flush kept 3", 32'(ld_full), 0);
         ld_alloc(nseq + 6'd4);
         chk(ld_full == 1, "R8 flush refill", 32'(ld_full), 1);
         nseq = nseq + 6'd5;
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule